// File: doc/BRIEF.md
# LPC Bus I/O and DMA Target

This block is the peripheral end of a Low Pin Count bus. It samples the frame strobe and the four multiplexed address/data lines on every clock and recognises the start of a cycle. It then decodes the cycle type and direction. Single-byte I/O reads and writes whose 16-bit address falls inside a configured window are passed to a byte-wide register port. Single-byte DMA transfers on the block's configured channel are passed to a byte-wide DMA port.

The target stays silent while the host owns the bus. After the host's two-clock turnaround it drives a ready SYNC nibble, then the read data if the cycle is a read, and then releases the lines. Every other cycle type is ignored. A frame strobe seen at any point aborts the current cycle, and the lines are released on the next clock. DMA service is requested by a short serial message on an open-drain-style request output.

Top module: `lpc_target`

## Requirements
- R1: While reset is low and after it is released, lad_oe is 0, ldrq_n is 1 and no strobe is high. A reset in the middle of a cycle abandons that cycle, and the rest of its nibbles cause no strobe and no drive.
- R2: I/O write (START 0000 with frame_n low, then type nibble 001x, four address nibbles most significant first, two data nibbles low first, two turnaround clocks). For an address inside [IO_BASE, IO_LAST], the next clock drives lad_out=0000 with lad_oe=1 and reg_wr=1, with reg_addr and reg_wdata holding the cycle's values. The lines are released on the clock after that.
- R3: I/O read (type 000x, four address nibbles, two turnaround clocks). For an address inside the window, the target drives SYNC 0000 with reg_rd=1, then the low nibble and then the high nibble of the reg_rdata value it sampled during SYNC. It then releases the lines.
- R4: An I/O cycle whose address is outside [IO_BASE, IO_LAST] produces no strobe and never drives the lines.
- R5: Cycle types other than 000x, 001x, 100x and 101x (for example memory, 010x) are ignored: no strobe and no drive.
- R6: frame_n sampled low in any state releases lad_oe on the next clock and abandons the current cycle. A START nibble in that same clock begins a new cycle, which then completes normally.
- R7: Several START nibbles while frame_n stays low are accepted, and the nibble after the last one is the cycle type. A non-zero nibble with frame_n low cancels the start.
- R8: DMA from the host (type 100x, then a channel nibble whose bits [2:0] equal DMA_CHAN, a size nibble 0000, two data nibbles low first, two turnaround clocks). The target drives SYNC 0000 with dma_wr=1 and the byte on reg_wdata for one clock, then releases the lines.
- R9: DMA to the host (type 101x, channel, size 0000, two turnaround clocks). The target drives SYNC with dma_rd=1, then the low and high nibbles of dma_rdata as sampled during SYNC, then releases the lines.
- R10: A DMA cycle with a different channel or a size nibble other than 0000 is ignored.
- R11: When dma_req changes level, ldrq_n sends 0, then DMA_CHAN bits 2, 1, 0, then the new dma_req level, one bit per clock, and then idles at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Interface reset, active low, asynchronous |
| frame_n | input | 1 | Cycle start / abort strobe, active low |
| lad_in | input | 4 | Sampled value of the multiplexed bus lines |
| lad_out | output | 4 | Value driven onto the bus lines |
| lad_oe | output | 1 | Enable for lad_out |
| reg_addr | output | 16 | I/O address of the current cycle |
| reg_wdata | output | 8 | Byte received from the host |
| reg_wr | output | 1 | One-clock I/O write strobe |
| reg_rd | output | 1 | One-clock I/O read strobe |
| reg_rdata | input | 8 | I/O read data, sampled during SYNC |
| dma_wr | output | 1 | One-clock strobe, DMA byte from the host |
| dma_rd | output | 1 | One-clock strobe, DMA byte to the host |
| dma_rdata | input | 8 | DMA byte to the host, sampled during SYNC |
| dma_req | input | 1 | Level request for DMA service |
| ldrq_n | output | 1 | Serial encoded DMA request |

## Verification
A wrong sequencer state shows at the bus lines within one or two clocks of the host's turnaround. The SYNC nibble then arrives a clock early or late, a read nibble is swapped, or a strobe fires for a cycle that should have been ignored. Faults in the abort path show one clock after frame_n falls, as lad_oe still high. A wrong channel, size or window decode shows as a missing or spurious strobe at SYNC time. An encoder fault shows as a bad bit within the five clocks after dma_req changes.

// File: rtl/lpc_target.sv
module lpc_target #(
  parameter logic [15:0] IO_BASE  = 16'h0060,
  parameter logic [15:0] IO_LAST  = 16'h006F,
  parameter logic [2:0]  DMA_CHAN = 3'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  lad_in,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic [15:0] reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_wr,
  output logic        reg_rd,
  input  logic [7:0]  reg_rdata,
  output logic        dma_wr,
  output logic        dma_rd,
  input  logic [7:0]  dma_rdata,
  input  logic        dma_req,
  output logic        ldrq_n
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CHAN, S_SIZE, S_WDAT, S_TAR, S_SYNC, S_RDAT
  } st_t;

  st_t         state;
  logic [1:0]  cnt;
  logic        host_wr;
  logic        is_dma;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] addr_nxt;
  logic        hit;

  assign addr_nxt = {addr[11:0], lad_in};
  assign hit      = (addr_nxt >= IO_BASE) && (addr_nxt <= IO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      host_wr <= 1'b0;
      is_dma  <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      rdata   <= '0;
    end else if (!frame_n) begin
      state <= (lad_in == 4'h0) ? S_START : S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_START: begin
          cnt <= '0;
          if (lad_in[3:2] == 2'b00) begin
            is_dma  <= 1'b0;
            host_wr <= lad_in[1];
            state   <= S_ADDR;
          end else if (lad_in[3:2] == 2'b10) begin
            is_dma  <= 1'b1;
            host_wr <= ~lad_in[1];
            state   <= S_CHAN;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ADDR: begin
          addr <= addr_nxt;
          cnt  <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            cnt   <= '0;
            state <= !hit ? S_IDLE : (host_wr ? S_WDAT : S_TAR);
          end
        end
        S_CHAN: state <= (lad_in[2:0] == DMA_CHAN) ? S_SIZE : S_IDLE;
        S_SIZE: state <= (lad_in == 4'h0) ? (host_wr ? S_WDAT : S_TAR) : S_IDLE;
        S_WDAT: begin
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin
            wdata[7:4] <= lad_in;
            cnt        <= '0;
            state      <= S_TAR;
          end else begin
            wdata[3:0] <= lad_in;
          end
        end
        S_TAR: begin
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin
            cnt   <= '0;
            state <= S_SYNC;
          end
        end
        S_SYNC: begin
          if (host_wr) begin
            state <= S_IDLE;
          end else begin
            rdata <= is_dma ? dma_rdata : reg_rdata;
            state <= S_RDAT;
          end
        end
        S_RDAT: begin
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin
            cnt   <= '0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign lad_oe    = (state == S_SYNC) || (state == S_RDAT);
  assign lad_out   = (state == S_RDAT) ? (cnt[0] ? rdata[7:4] : rdata[3:0]) : 4'h0;
  assign reg_addr  = addr;
  assign reg_wdata = wdata;
  assign reg_wr    = (state == S_SYNC) && !is_dma &&  host_wr;
  assign reg_rd    = (state == S_SYNC) && !is_dma && !host_wr;
  assign dma_wr    = (state == S_SYNC) &&  is_dma &&  host_wr;
  assign dma_rd    = (state == S_SYNC) &&  is_dma && !host_wr;

  logic [4:0] rq_sh;
  logic [2:0] rq_left;
  logic       rq_sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_sh   <= '0;
      rq_left <= '0;
      rq_sent <= 1'b0;
    end else if (rq_left != 3'd0) begin
      rq_sh   <= {rq_sh[3:0], 1'b1};
      rq_left <= rq_left - 3'd1;
    end else if (dma_req != rq_sent) begin
      rq_sh   <= {1'b0, DMA_CHAN, dma_req};
      rq_left <= 3'd5;
      rq_sent <= dma_req;
    end
  end

  assign ldrq_n = (rq_left != 3'd0) ? rq_sh[4] : 1'b1;
endmodule

// File: rtl/lpc_target_chk.sv
module lpc_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       dma_wr,
  input logic       ldrq_n
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!lad_oe && ldrq_n)); // R1
  AST_WR_SYNC: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> (lad_oe && lad_out == 4'h0)); // R2
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr || dma_wr) |=> !lad_oe); // R8
  AST_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && frame_n) |=> lad_oe); // R3
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !frame_n |=> !lad_oe); // R6
endmodule

bind lpc_target lpc_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_out(lad_out), .lad_oe(lad_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .dma_wr(dma_wr), .ldrq_n(ldrq_n)
);

// File: tb/tb_lpc_target.sv
module tb_lpc_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic lad_oe;
  logic [15:0] reg_addr;
  logic [7:0] reg_wdata;
  logic reg_wr, reg_rd, dma_wr, dma_rd, ldrq_n;
  logic [7:0] reg_rdata = 8'hA5;
  logic [7:0] dma_rdata = 8'h3C;
  logic dma_req = 1'b0;

  int total = 0, failed = 0;
  int wr_cnt = 0, rd_cnt = 0, dw_cnt = 0, dr_cnt = 0, oe_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpc_target dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .dma_wr(dma_wr), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .dma_req(dma_req), .ldrq_n(ldrq_n)
  );

  always @(posedge clk) begin
    if (reg_wr) wr_cnt++;
    if (reg_rd) rd_cnt++;
    if (dma_wr) dw_cnt++;
    if (dma_rd) dr_cnt++;
    if (lad_oe) oe_cnt++;
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    lad_in  = n;
  endtask

  task automatic idle_bus(input int n);
    for (int i = 0; i < n; i++) drv(1'b1, 4'hF);
  endtask

  task automatic send_addr(input logic [15:0] a);
    drv(1, a[15:12]); drv(1, a[11:8]); drv(1, a[7:4]); drv(1, a[3:0]);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", lad_oe, 0);
    chk("R1 ldrq in reset", ldrq_n, 1);
    chk("R1 strobes in reset", {reg_wr, reg_rd, dma_wr, dma_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", lad_oe, 0);
    chk("R1 ldrq after reset", ldrq_n, 1);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input bit hit, input string r);
    int w0 = wr_cnt;
    int o0 = oe_cnt;
    drv(0, 4'h0); drv(1, 4'h2); send_addr(a);
    drv(1, d[3:0]); drv(1, d[7:4]); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    lad_in = 4'hF;
    if (hit) begin
      chk({r, " sync oe"}, lad_oe, 1);
      chk({r, " sync nibble"}, lad_out, 0);
      chk({r, " wr strobe"}, reg_wr, 1);
      chk({r, " addr"}, reg_addr, a);
      chk({r, " wdata"}, reg_wdata, d);
    end
    @(negedge clk);
    chk({r, " released"}, lad_oe, 0);
    chk({r, " write count"}, wr_cnt - w0, hit ? 1 : 0);
    chk({r, " drive cycles"}, oe_cnt - o0, hit ? 1 : 0);
  endtask

  task automatic io_read(input logic [15:0] a, input bit hit, input string r);
    int r0 = rd_cnt;
    int o0 = oe_cnt;
    drv(0, 4'h0); drv(1, 4'h0); send_addr(a); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    if (hit) begin
      chk({r, " sync"}, {lad_oe, lad_out, reg_rd}, {1'b1, 4'h0, 1'b1});
      chk({r, " addr"}, reg_addr, a);
    end
    @(negedge clk);
    if (hit) chk({r, " low nibble"}, {lad_oe, lad_out}, {1'b1, reg_rdata[3:0]});
    @(negedge clk);
    if (hit) chk({r, " high nibble"}, {lad_oe, lad_out}, {1'b1, reg_rdata[7:4]});
    @(negedge clk);
    chk({r, " released"}, lad_oe, 0);
    chk({r, " read count"}, rd_cnt - r0, hit ? 1 : 0);
    chk({r, " drive cycles"}, oe_cnt - o0, hit ? 3 : 0);
  endtask

  task automatic t_unsupported;
    int s0 = wr_cnt + rd_cnt + dw_cnt + dr_cnt;
    int o0 = oe_cnt;
    drv(0, 4'h0); drv(1, 4'h4);
    for (int i = 0; i < 8; i++) drv(1, 4'h0);
    idle_bus(4);
    drv(0, 4'h0); drv(1, 4'hE); idle_bus(10);
    chk("R5 no strobe on memory/reserved types", wr_cnt + rd_cnt + dw_cnt + dr_cnt - s0, 0);
    chk("R5 never drives", oe_cnt - o0, 0);
  endtask

  task automatic t_abort;
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    drv(0, 4'h0); drv(1, 4'h2); drv(1, 4'h0); drv(1, 4'h0); drv(1, 4'h6);
    drv(0, 4'h0); drv(1, 4'h2); send_addr(16'h0064);
    drv(1, 4'h7); drv(1, 4'hE); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    lad_in = 4'hF;
    chk("R6 restarted write addr", reg_addr, 16'h0064);
    chk("R6 restarted write data", reg_wdata, 8'hE7);
    chk("R6 restarted write strobe", reg_wr, 1);
    @(negedge clk);
    chk("R6 single write after abort", wr_cnt - w0, 1);
    drv(0, 4'h0); drv(1, 4'h0); send_addr(16'h0061); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    chk("R6 read reached sync", lad_oe, 1);
    drv(0, 4'hF);
    @(negedge clk);
    chk("R6 oe released one clock after frame", lad_oe, 0);
    frame_n = 1'b1;
    idle_bus(3);
    chk("R6 no drive after abort", lad_oe, 0);
    chk("R6 read strobe count", rd_cnt - r0, 1);
  endtask

  task automatic t_multi_start;
    int w0 = wr_cnt;
    int o0 = oe_cnt;
    drv(0, 4'h0); drv(0, 4'h0); drv(0, 4'h0); drv(1, 4'h2); send_addr(16'h0062);
    drv(1, 4'h1); drv(1, 4'h9); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    lad_in = 4'hF;
    chk("R7 repeated start write strobe", reg_wr, 1);
    chk("R7 repeated start data", reg_wdata, 8'h91);
    @(negedge clk);
    drv(0, 4'h0); drv(0, 4'h3); drv(1, 4'h2); send_addr(16'h0062);
    drv(1, 4'h1); drv(1, 4'h9); idle_bus(6);
    chk("R7 cancelled start writes once only", wr_cnt - w0, 1);
    chk("R7 cancelled start drive cycles", oe_cnt - o0, 1);
  endtask

  task automatic t_dma_in;
    int d0 = dw_cnt;
    drv(0, 4'h0); drv(1, 4'h8); drv(1, 4'h2); drv(1, 4'h0);
    drv(1, 4'hD); drv(1, 4'h4); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    lad_in = 4'hF;
    chk("R8 dma sync", {lad_oe, lad_out, dma_wr}, {1'b1, 4'h0, 1'b1});
    chk("R8 dma byte", reg_wdata, 8'h4D);
    @(negedge clk);
    chk("R8 dma released", lad_oe, 0);
    chk("R8 dma strobe count", dw_cnt - d0, 1);
  endtask

  task automatic t_dma_out;
    int d0 = dr_cnt;
    drv(0, 4'h0); drv(1, 4'hA); drv(1, 4'hA); drv(1, 4'h0); drv(1, 4'hF); drv(1, 4'hF);
    @(negedge clk);
    chk("R9 dma sync", {lad_oe, lad_out, dma_rd}, {1'b1, 4'h0, 1'b1});
    @(negedge clk);
    chk("R9 dma low nibble", {lad_oe, lad_out}, {1'b1, dma_rdata[3:0]});
    @(negedge clk);
    chk("R9 dma high nibble", {lad_oe, lad_out}, {1'b1, dma_rdata[7:4]});
    @(negedge clk);
    chk("R9 dma released", lad_oe, 0);
    chk("R9 dma strobe count", dr_cnt - d0, 1);
  endtask

  task automatic t_dma_ignored;
    int s0 = dw_cnt + dr_cnt;
    int o0 = oe_cnt;
    drv(0, 4'h0); drv(1, 4'h8); drv(1, 4'h3); drv(1, 4'h0);
    drv(1, 4'h1); drv(1, 4'h1); idle_bus(6);
    drv(0, 4'h0); drv(1, 4'hA); drv(1, 4'h2); drv(1, 4'h1); idle_bus(8);
    chk("R10 wrong channel or size: no strobe", dw_cnt + dr_cnt - s0, 0);
    chk("R10 wrong channel or size: no drive", oe_cnt - o0, 0);
  endtask

  task automatic t_ldrq;
    logic [5:0] up = 6'b001011;
    logic [5:0] dn = 6'b001001;
    @(negedge clk);
    dma_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R11 request message bit", ldrq_n, up[5 - i]);
    end
    dma_req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R11 withdraw message bit", ldrq_n, dn[5 - i]);
    end
  endtask

  task automatic t_mid_reset;
    int w0 = wr_cnt;
    int o0 = oe_cnt;
    drv(0, 4'h0); drv(1, 4'h2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 oe during mid-cycle reset", lad_oe, 0);
    rst_n = 1'b1;
    send_addr(16'h0063); drv(1, 4'h1); drv(1, 4'h2); idle_bus(6);
    chk("R1 abandoned cycle writes nothing", wr_cnt - w0, 0);
    chk("R1 abandoned cycle drives nothing", oe_cnt - o0, 0);
  endtask

  initial begin
    t_reset();
    idle_bus(2);
    io_write(16'h0063, 8'h5C, 1'b1, "R2 write in window");
    io_write(16'h0060, 8'hA1, 1'b1, "R2 write at window base");
    io_read(16'h006F, 1'b1, "R3 read at window top");
    reg_rdata = 8'h96;
    io_read(16'h0065, 1'b1, "R3 read second pattern");
    io_write(16'h0070, 8'h11, 1'b0, "R4 write above window");
    io_read(16'h005F, 1'b0, "R4 read below window");
    t_unsupported();
    t_abort();
    t_multi_start();
    t_dma_in();
    t_dma_out();
    t_dma_ignored();
    t_ldrq();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule